// File: doc/BRIEF.md
# Reset Cause and Sleep Status Tracker

This block holds the reset-cause and sleep-status flags of a small microcontroller core and chooses where the program counter restarts after a reset or a wake-up. Seven single-cycle event strobes arrive from the surrounding core: power-on, brown-out, external reset pin while running or sleeping, watchdog expiry while running or sleeping, and interrupt wake-up from sleep. Each event leaves its own pattern on four flags: time-out, power-down, power-on and brown-out. Together these patterns let firmware tell after the fact what restarted it.

Every event also loads a restart vector one cycle after its strobe, and a one-cycle valid pulse marks it. A true reset restarts at the reset vector. A watchdog wake-up resumes at the next instruction. An interrupt wake-up resumes at the next instruction, or at the interrupt vector when global interrupts are enabled. The sleep and clear-watchdog instructions update the time-out and power-down flags. Software may write the power-on and brown-out flags and the upper bank-select bits.

Top module: `rst_status_tracker`

## Requirements
- R1: A power-on strobe sets time-out=1 and power-down=1, clears the power-on flag, leaves the brown-out flag unchanged, clears the bank bits, and loads the reset vector (000h). Flags, bank bits and vector all take effect on the clock edge that samples the strobe.
- R2: A brown-out strobe sets time-out=1 and power-down=1, clears the brown-out flag, leaves the power-on flag unchanged, clears the bank bits and loads the reset vector.
- R3: A watchdog expiry while running sets time-out=0 and power-down=1, clears the bank bits and loads the reset vector.
- R4: A watchdog wake-up from sleep sets time-out=0 and power-down=0, keeps the bank bits, and loads pc_i+1, which wraps modulo 2^PC_W.
- R5: An external reset while running leaves time-out and power-down unchanged. An external reset while sleeping sets time-out=1 and power-down=0. Both clear the bank bits and load the reset vector.
- R6: An interrupt wake-up sets time-out=1 and power-down=0 and keeps the bank bits. It loads the interrupt vector (004h) when gie_i=1 and pc_i+1 when gie_i=0.
- R7: A bank write stores bank_d_i unless a reset event (R1, R2, R3, R5) occurs in the same cycle. A reset event clears the bank bits and wins over the write.
- R8: The power-on and brown-out flags change only on their own strobe or on a software write. A software write made in the same cycle as any of the seven event strobes is ignored.
- R9: The pair time-out=0, power-down=0 arises only from a watchdog wake-up from sleep.
- R10: With no event strobe present, a sleep instruction sets time-out=1 and power-down=0, and a clear-watchdog instruction sets both to 1. Clear-watchdog wins if both occur together. Neither instruction loads a vector.
- R11: Simultaneous event strobes resolve in this order: power-on, brown-out, external reset (running before sleeping), watchdog (running before sleeping), interrupt wake-up. Only the winner takes effect.
- R12: While rst_ni is low, time-out=1, power-down=1, power-on=0, brown-out=0, bank=0 and the valid pulse is 0. The vector valid pulse lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| por_evt_i | input | 1 | Power-on event strobe |
| bod_evt_i | input | 1 | Brown-out event strobe |
| ext_run_evt_i | input | 1 | External reset while running |
| ext_slp_evt_i | input | 1 | External reset while sleeping |
| wdt_run_evt_i | input | 1 | Watchdog expiry while running |
| wdt_slp_evt_i | input | 1 | Watchdog wake-up from sleep |
| irq_wake_i | input | 1 | Interrupt wake-up from sleep |
| gie_i | input | 1 | Global interrupt enable level |
| sleep_op_i | input | 1 | Sleep instruction strobe |
| clrwdt_op_i | input | 1 | Clear-watchdog instruction strobe |
| pc_i | input | PC_W | Current program counter |
| sw_wr_i | input | 1 | Software write of power-on/brown-out flags |
| sw_pof_i | input | 1 | Written power-on flag value |
| sw_bof_i | input | 1 | Written brown-out flag value |
| bank_wr_i | input | 1 | Bank bits write strobe |
| bank_d_i | input | BANK_W | Bank bits write data |
| tmo_o | output | 1 | Time-out flag |
| pdn_o | output | 1 | Power-down flag |
| pof_o | output | 1 | Power-on flag (0 after power-on) |
| bof_o | output | 1 | Brown-out flag (0 after brown-out) |
| bank_o | output | BANK_W | Upper bank-select bits |
| vec_valid_o | output | 1 | Restart vector valid pulse |
| vec_o | output | PC_W | Restart vector |

## Verification
The bench builds the block with PC_W=13, BANK_W=3, a reset vector of 000h and an interrupt vector of 004h. A 13-bit counter lets a single wake-up at pc 1FFFh show the wrap to 0000h. A non-zero interrupt vector cannot be mistaken for a reset restart or for pc+1. Three bank bits preloaded with 101b make clearing and keeping plainly distinct after each event.

// File: rtl/rst_stat_pkg.sv
package rst_stat_pkg;
  localparam int unsigned NUM_SRC   = 7;
  localparam int unsigned SRC_IDX_W = $clog2(NUM_SRC);

  // bit order of the source vector, lowest index = lowest priority
  localparam int unsigned SRC_IRQ     = 0;
  localparam int unsigned SRC_WDT_SLP = 1;
  localparam int unsigned SRC_WDT_RUN = 2;
  localparam int unsigned SRC_EXT_SLP = 3;
  localparam int unsigned SRC_EXT_RUN = 4;
  localparam int unsigned SRC_BOD     = 5;
  localparam int unsigned SRC_POR     = 6;

  typedef enum logic [3:0] {
    EV_NONE,
    EV_POR,
    EV_BOD,
    EV_EXT_RUN,
    EV_EXT_SLP,
    EV_WDT_RUN,
    EV_WDT_SLP,
    EV_IRQ,
    EV_SLEEP_OP,
    EV_CLRWDT_OP
  } ev_t;

  function automatic logic ev_is_reset(ev_t e);
    return (e == EV_POR) || (e == EV_BOD) || (e == EV_EXT_RUN) ||
           (e == EV_EXT_SLP) || (e == EV_WDT_RUN);
  endfunction

  function automatic logic ev_is_src(ev_t e);
    return ev_is_reset(e) || (e == EV_WDT_SLP) || (e == EV_IRQ);
  endfunction
endpackage

// File: rtl/rst_cause_arb.sv
module rst_cause_arb
  import rst_stat_pkg::*;
(
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               sleep_op_i,
  input  logic               clrwdt_op_i,
  output ev_t                ev_o
);
  logic [SRC_IDX_W-1:0] win;
  logic                 hit;

  // later (higher) index overrides lower
  always_comb begin
    win = '0;
    hit = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (src_i[i]) begin
        win = SRC_IDX_W'(i);
        hit = 1'b1;
      end
    end
  end

  always_comb begin
    ev_o = EV_NONE;
    if (hit) begin
      case (int'(win))
        SRC_POR:     ev_o = EV_POR;
        SRC_BOD:     ev_o = EV_BOD;
        SRC_EXT_RUN: ev_o = EV_EXT_RUN;
        SRC_EXT_SLP: ev_o = EV_EXT_SLP;
        SRC_WDT_RUN: ev_o = EV_WDT_RUN;
        SRC_WDT_SLP: ev_o = EV_WDT_SLP;
        default:     ev_o = EV_IRQ;
      endcase
    end else if (clrwdt_op_i) begin
      ev_o = EV_CLRWDT_OP;
    end else if (sleep_op_i) begin
      ev_o = EV_SLEEP_OP;
    end
  end
endmodule

// File: rtl/rst_flag_regs.sv
module rst_flag_regs
  import rst_stat_pkg::*;
#(
  parameter int unsigned BANK_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ev_t               ev_i,
  input  logic              sw_wr_i,
  input  logic              sw_pof_i,
  input  logic              sw_bof_i,
  input  logic              bank_wr_i,
  input  logic [BANK_W-1:0] bank_d_i,
  output logic              tmo_o,
  output logic              pdn_o,
  output logic              pof_o,
  output logic              bof_o,
  output logic [BANK_W-1:0] bank_o
);
  logic              tmo_d, pdn_d, pof_d, bof_d;
  logic [BANK_W-1:0] bank_d;

  always_comb begin
    tmo_d  = tmo_o;
    pdn_d  = pdn_o;
    pof_d  = pof_o;
    bof_d  = bof_o;
    bank_d = bank_o;

    if (sw_wr_i && !ev_is_src(ev_i)) begin
      pof_d = sw_pof_i;
      bof_d = sw_bof_i;
    end
    if (bank_wr_i) bank_d = bank_d_i;
    if (ev_is_reset(ev_i)) bank_d = '0;

    case (ev_i)
      EV_POR:       begin tmo_d = 1'b1; pdn_d = 1'b1; pof_d = 1'b0; end
      EV_BOD:       begin tmo_d = 1'b1; pdn_d = 1'b1; bof_d = 1'b0; end
      EV_EXT_SLP:   begin tmo_d = 1'b1; pdn_d = 1'b0; end
      EV_WDT_RUN:   begin tmo_d = 1'b0; pdn_d = 1'b1; end
      EV_WDT_SLP:   begin tmo_d = 1'b0; pdn_d = 1'b0; end
      EV_IRQ:       begin tmo_d = 1'b1; pdn_d = 1'b0; end
      EV_SLEEP_OP:  begin tmo_d = 1'b1; pdn_d = 1'b0; end
      EV_CLRWDT_OP: begin tmo_d = 1'b1; pdn_d = 1'b1; end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmo_o  <= 1'b1;
      pdn_o  <= 1'b1;
      pof_o  <= 1'b0;
      bof_o  <= 1'b0;
      bank_o <= '0;
    end else begin
      tmo_o  <= tmo_d;
      pdn_o  <= pdn_d;
      pof_o  <= pof_d;
      bof_o  <= bof_d;
      bank_o <= bank_d;
    end
  end
endmodule

// File: rtl/rst_vec_sel.sv
module rst_vec_sel
  import rst_stat_pkg::*;
#(
  parameter int unsigned  PC_W      = 13,
  parameter logic [PC_W-1:0] RESET_VEC = '0,
  parameter logic [PC_W-1:0] IRQ_VEC   = PC_W'(4)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  ev_t             ev_i,
  input  logic            gie_i,
  input  logic [PC_W-1:0] pc_i,
  output logic            vec_valid_o,
  output logic [PC_W-1:0] vec_o
);
  logic [PC_W-1:0] resume_pc;
  logic [PC_W-1:0] vec_d;

  assign resume_pc = pc_i + PC_W'(1);

  always_comb begin
    if (ev_is_reset(ev_i))       vec_d = RESET_VEC;
    else if (ev_i == EV_IRQ)     vec_d = gie_i ? IRQ_VEC : resume_pc;
    else if (ev_i == EV_WDT_SLP) vec_d = resume_pc;
    else                         vec_d = vec_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_valid_o <= 1'b0;
      vec_o       <= RESET_VEC;
    end else begin
      vec_valid_o <= ev_is_src(ev_i);
      vec_o       <= vec_d;
    end
  end
endmodule

// File: rtl/rst_status_tracker.sv
module rst_status_tracker
  import rst_stat_pkg::*;
#(
  parameter int unsigned     PC_W      = 13,
  parameter int unsigned     BANK_W    = 3,
  parameter logic [PC_W-1:0] RESET_VEC = '0,
  parameter logic [PC_W-1:0] IRQ_VEC   = PC_W'(4)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              por_evt_i,
  input  logic              bod_evt_i,
  input  logic              ext_run_evt_i,
  input  logic              ext_slp_evt_i,
  input  logic              wdt_run_evt_i,
  input  logic              wdt_slp_evt_i,
  input  logic              irq_wake_i,
  input  logic              gie_i,
  input  logic              sleep_op_i,
  input  logic              clrwdt_op_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic              sw_wr_i,
  input  logic              sw_pof_i,
  input  logic              sw_bof_i,
  input  logic              bank_wr_i,
  input  logic [BANK_W-1:0] bank_d_i,
  output logic              tmo_o,
  output logic              pdn_o,
  output logic              pof_o,
  output logic              bof_o,
  output logic [BANK_W-1:0] bank_o,
  output logic              vec_valid_o,
  output logic [PC_W-1:0]   vec_o
);
  logic [NUM_SRC-1:0] src;
  ev_t                ev;

  always_comb begin
    src              = '0;
    src[SRC_POR]     = por_evt_i;
    src[SRC_BOD]     = bod_evt_i;
    src[SRC_EXT_RUN] = ext_run_evt_i;
    src[SRC_EXT_SLP] = ext_slp_evt_i;
    src[SRC_WDT_RUN] = wdt_run_evt_i;
    src[SRC_WDT_SLP] = wdt_slp_evt_i;
    src[SRC_IRQ]     = irq_wake_i;
  end

  rst_cause_arb u_arb (
    .src_i       (src),
    .sleep_op_i  (sleep_op_i),
    .clrwdt_op_i (clrwdt_op_i),
    .ev_o        (ev)
  );

  rst_flag_regs #(.BANK_W(BANK_W)) u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ev_i      (ev),
    .sw_wr_i   (sw_wr_i),
    .sw_pof_i  (sw_pof_i),
    .sw_bof_i  (sw_bof_i),
    .bank_wr_i (bank_wr_i),
    .bank_d_i  (bank_d_i),
    .tmo_o     (tmo_o),
    .pdn_o     (pdn_o),
    .pof_o     (pof_o),
    .bof_o     (bof_o),
    .bank_o    (bank_o)
  );

  rst_vec_sel #(
    .PC_W      (PC_W),
    .RESET_VEC (RESET_VEC),
    .IRQ_VEC   (IRQ_VEC)
  ) u_vec (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ev_i        (ev),
    .gie_i       (gie_i),
    .pc_i        (pc_i),
    .vec_valid_o (vec_valid_o),
    .vec_o       (vec_o)
  );
endmodule

// File: rtl/rst_status_tracker_chk.sv
module rst_status_tracker_chk #(
  parameter int unsigned     PC_W      = 13,
  parameter int unsigned     BANK_W    = 3,
  parameter logic [PC_W-1:0] RESET_VEC = '0,
  parameter logic [PC_W-1:0] IRQ_VEC   = PC_W'(4)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              por_evt_i,
  input logic              bod_evt_i,
  input logic              ext_run_evt_i,
  input logic              ext_slp_evt_i,
  input logic              wdt_run_evt_i,
  input logic              wdt_slp_evt_i,
  input logic              irq_wake_i,
  input logic              gie_i,
  input logic              sleep_op_i,
  input logic              clrwdt_op_i,
  input logic [PC_W-1:0]   pc_i,
  input logic              sw_wr_i,
  input logic              sw_pof_i,
  input logic              sw_bof_i,
  input logic              bank_wr_i,
  input logic [BANK_W-1:0] bank_d_i,
  input logic              tmo_o,
  input logic              pdn_o,
  input logic              pof_o,
  input logic              bof_o,
  input logic [BANK_W-1:0] bank_o,
  input logic              vec_valid_o,
  input logic [PC_W-1:0]   vec_o
);
  logic any_rst, any_wake;
  assign any_rst  = por_evt_i | bod_evt_i | ext_run_evt_i | ext_slp_evt_i | wdt_run_evt_i;
  assign any_wake = wdt_slp_evt_i | irq_wake_i;

  AST_POR_OUTCOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_evt_i |=> (tmo_o && pdn_o && !pof_o && vec_valid_o && vec_o == RESET_VEC && bank_o == '0)); // R1

  AST_IRQ_VECTOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_wake_i && gie_i && !any_rst && !wdt_slp_evt_i) |=> (vec_valid_o && vec_o == IRQ_VEC)); // R6

  AST_WAKE_KEEPS_BANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (any_wake && !any_rst && !bank_wr_i) |=> (bank_o == $past(bank_o))); // R7

  AST_BOF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bod_evt_i && !sw_wr_i) |=> $stable(bof_o)); // R8

  AST_ZERO_PAIR_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(tmo_o == 1'b0 && pdn_o == 1'b0) && !wdt_slp_evt_i) |=> !(tmo_o == 1'b0 && pdn_o == 1'b0)); // R9

  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!any_rst && !any_wake) |=> !vec_valid_o); // R12
endmodule

bind rst_status_tracker rst_status_tracker_chk #(
  .PC_W      (PC_W),
  .BANK_W    (BANK_W),
  .RESET_VEC (RESET_VEC),
  .IRQ_VEC   (IRQ_VEC)
) u_chk (.*);

// File: tb/rst_status_tracker_test.sv
`timescale 1ns/1ps
module rst_status_tracker_test;
  localparam int unsigned PC_W   = 13;
  localparam int unsigned BANK_W = 3;
  // row: ev[36:30] {por,bod,ext_run,ext_slp,wdt_run,wdt_slp,irq}, gie[29], pc[28:16],
  //      tmo[15], pdn[14], bank_clr[13], vec[12:0]
  localparam int unsigned ROW_W = 37;
  localparam int unsigned NROWS = 14;
  localparam logic [ROW_W-1:0] TBL [NROWS] = '{
    {7'b1000000, 1'b0, 13'h0123, 1'b1, 1'b1, 1'b1, 13'h0000}, // R1 por
    {7'b0000100, 1'b0, 13'h0123, 1'b0, 1'b1, 1'b1, 13'h0000}, // R3 wdt run
    {7'b0010000, 1'b0, 13'h0123, 1'b0, 1'b1, 1'b1, 13'h0000}, // R5 ext run keeps 0/1
    {7'b0000010, 1'b0, 13'h0123, 1'b0, 1'b0, 1'b0, 13'h0124}, // R4 wdt wake
    {7'b0001000, 1'b0, 13'h0123, 1'b1, 1'b0, 1'b1, 13'h0000}, // R5 ext sleep
    {7'b0000001, 1'b0, 13'h0123, 1'b1, 1'b0, 1'b0, 13'h0124}, // R6 irq gie=0
    {7'b0000001, 1'b1, 13'h0123, 1'b1, 1'b0, 1'b0, 13'h0004}, // R6 irq gie=1
    {7'b0100000, 1'b0, 13'h0123, 1'b1, 1'b1, 1'b1, 13'h0000}, // R2 bod
    {7'b0010000, 1'b0, 13'h0040, 1'b1, 1'b1, 1'b1, 13'h0000}, // R5 ext run keeps 1/1
    {7'b1000001, 1'b1, 13'h0123, 1'b1, 1'b1, 1'b1, 13'h0000}, // R11 por over irq
    {7'b0000011, 1'b1, 13'h0200, 1'b0, 1'b0, 1'b0, 13'h0201}, // R11 wdt wake over irq
    {7'b0100100, 1'b0, 13'h0123, 1'b1, 1'b1, 1'b1, 13'h0000}, // R11 bod over wdt run
    {7'b0010010, 1'b0, 13'h0123, 1'b1, 1'b1, 1'b1, 13'h0000}, // R11 ext run over wdt wake
    {7'b0000010, 1'b0, 13'h1FFF, 1'b0, 1'b0, 1'b0, 13'h0000}  // R4 wrap
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic por_evt_i = 0, bod_evt_i = 0, ext_run_evt_i = 0, ext_slp_evt_i = 0;
  logic wdt_run_evt_i = 0, wdt_slp_evt_i = 0, irq_wake_i = 0, gie_i = 0;
  logic sleep_op_i = 0, clrwdt_op_i = 0, sw_wr_i = 0, sw_pof_i = 0, sw_bof_i = 0;
  logic bank_wr_i = 0;
  logic [BANK_W-1:0] bank_d_i = '0;
  logic [PC_W-1:0]   pc_i = '0;
  logic tmo_o, pdn_o, pof_o, bof_o, vec_valid_o;
  logic [BANK_W-1:0] bank_o;
  logic [PC_W-1:0]   vec_o;

  int errors = 0;
  int checks = 0;

  always #2.5 clk_i = ~clk_i;

  rst_status_tracker #(
    .PC_W(PC_W), .BANK_W(BANK_W), .RESET_VEC(13'h000), .IRQ_VEC(13'h004)
  ) uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_ev(input logic [6:0] ev);
    {por_evt_i, bod_evt_i, ext_run_evt_i, ext_slp_evt_i,
     wdt_run_evt_i, wdt_slp_evt_i, irq_wake_i} = ev;
  endtask

  // inputs already set; let one edge pass, then clear strobes
  task automatic tick();
    @(negedge clk_i);
    set_ev('0);
    {sleep_op_i, clrwdt_op_i, sw_wr_i, bank_wr_i, gie_i} = '0;
  endtask

  task automatic bank_preload(input logic [BANK_W-1:0] v);
    bank_wr_i = 1'b1; bank_d_i = v; tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++; checks++;
    $display("FAIL watchdog: actual=hang expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R12 reset state
    chk("R12 tmo", tmo_o, 1); chk("R12 pdn", pdn_o, 1);
    chk("R12 pof", pof_o, 0); chk("R12 bof", bof_o, 0);
    chk("R12 bank", bank_o, 0); chk("R12 valid", vec_valid_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int r = 0; r < NROWS; r++) begin
      logic [ROW_W-1:0] row;
      row = TBL[r];
      bank_preload(3'b101);
      chk($sformatf("R7 preload row %0d", r), bank_o, 3'b101);
      set_ev(row[36:30]); gie_i = row[29]; pc_i = row[28:16];
      tick();
      chk($sformatf("R1-row %0d tmo", r), tmo_o, row[15]);
      chk($sformatf("R9 row %0d pdn", r), pdn_o, row[14]);
      chk($sformatf("R7 row %0d bank", r), bank_o, row[13] ? 3'b000 : 3'b101);
      chk($sformatf("R12 row %0d valid", r), vec_valid_o, 1);
      chk($sformatf("R11 row %0d vec", r), vec_o, row[12:0]);
    end
    @(negedge clk_i);
    chk("R12 valid drops", vec_valid_o, 0);

    // R8 software write and isolation of pof/bof
    sw_wr_i = 1; sw_pof_i = 1; sw_bof_i = 1; tick();
    chk("R8 pof write", pof_o, 1); chk("R8 bof write", bof_o, 1);
    set_ev(7'b0010000); tick();
    set_ev(7'b0000100); tick();
    set_ev(7'b0000001); tick();
    set_ev(7'b0000010); tick();
    chk("R8 pof held", pof_o, 1); chk("R8 bof held", bof_o, 1);
    set_ev(7'b0100000); sw_wr_i = 1; sw_pof_i = 0; sw_bof_i = 1; tick();
    chk("R2 bof cleared", bof_o, 0); chk("R2 pof kept", pof_o, 1);
    sw_wr_i = 1; sw_pof_i = 1; sw_bof_i = 1; tick();
    set_ev(7'b1000000); tick();
    chk("R1 pof cleared", pof_o, 0); chk("R1 bof kept", bof_o, 1);

    // R7 reset wins over bank write, wake lets write through
    bank_wr_i = 1; bank_d_i = 3'b110; set_ev(7'b0000100); tick();
    chk("R7 reset beats write", bank_o, 0);
    bank_wr_i = 1; bank_d_i = 3'b011; set_ev(7'b0000001); tick();
    chk("R7 write on wake", bank_o, 3'b011);

    // R10 instruction updates
    sleep_op_i = 1; tick();
    chk("R10 sleep tmo", tmo_o, 1); chk("R10 sleep pdn", pdn_o, 0);
    chk("R10 sleep no vec", vec_valid_o, 0);
    clrwdt_op_i = 1; tick();
    chk("R10 clrwdt tmo", tmo_o, 1); chk("R10 clrwdt pdn", pdn_o, 1);
    sleep_op_i = 1; clrwdt_op_i = 1; tick();
    chk("R10 clrwdt wins", pdn_o, 1);
    sleep_op_i = 1; set_ev(7'b0000100); tick();
    chk("R10 event beats sleep tmo", tmo_o, 0); chk("R10 event beats sleep pdn", pdn_o, 1);

    // R12 asynchronous reset mid-run
    set_ev(7'b0000010); tick();
    rst_ni = 1'b0; #1;
    chk("R12 async tmo", tmo_o, 1); chk("R12 async pdn", pdn_o, 1);
    chk("R12 async bof", bof_o, 0);
    @(negedge clk_i); rst_ni = 1'b1; @(negedge clk_i);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule